// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block carries out the memory-moving instructions of a small 16-bit load/store machine over several clock cycles. When `start` is pulsed it captures the instruction word and forms an effective address. The address comes either from the incremented program counter plus a sign-extended 9-bit offset, or from a base register plus a sign-extended 6-bit offset. The block then drives a single-port synchronous memory through its own address register (MAR) and data register (MDR), and writes the result back to the register file or stores a register to memory.

Pointer-chasing loads and stores make two trips through the memory address register. The first read returns an address, and that address is used for the real access. The address-only instruction forms the pc-relative address, writes it to a register and never touches memory. A one-cycle `done` pulse marks completion. The surrounding core must hold `pc_inc` steady until `done`. The instruction word is captured at acceptance, so it need not be held.

Top module: `ldst_seq`

## Requirements
- R1: While reset is held and after its release, `done`, `busy`, `mem_rd`, `mem_wr`, `wb_en` and `cc_upd` are low until an instruction is accepted.
- R2: For opcodes 0010 (load) and 0011 (store), the memory address is `pc_inc` plus bits [8:0] of the instruction sign-extended to 16 bits.
- R3: For opcodes 0110 (load) and 0111 (store), the memory address is the register named by bits [8:6] plus bits [5:0] sign-extended, so offsets run from -32 to +31.
- R4: For opcodes 1010 (indirect load) and 1011 (indirect store), a first read is made at the pc-relative address, and the word it returns is the address of the second access.
- R5: For opcode 1110, the register named by bits [11:9] receives `pc_inc` plus sign-extended bits [8:0], and no memory read or write is issued.
- R6: Loads write the word read from memory into the register named by bits [11:9]. Stores write that register's value to memory and perform no register write.
- R7: `cc_upd` is high exactly in the cycle of a register write-back, so it is raised for loads and opcode 1110 and never for stores.
- R8: Counting rising edges from the edge that samples `start` to the edge after which `done` is high, the latency is 2 for opcode 1110, 3 for 0011/0111, 4 for 0010/0110, 6 for 1011, 7 for 1010 and 1 for any other opcode.
- R9: Any opcode outside the seven above completes without a memory strobe and without a register write.
- R10: `done` is a one-cycle pulse, and `start` and `instr` are ignored from acceptance until `done`.
- R11: `mem_rd` and `mem_wr` are never high together, each strobe lasts one cycle, and the read word is captured one cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept `instr` when idle |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Incremented program counter, held until `done` |
| rf_rd_idx | output | 3 | Register-file read index |
| rf_rd_data | input | 16 | Register-file read data (combinational) |
| mem_addr | output | 16 | Memory address (MAR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (MDR) |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| wb_en | output | 1 | Register write enable |
| wb_idx | output | 3 | Register write index |
| wb_data | output | 16 | Register write data |
| cc_upd | output | 1 | Condition codes are to be updated |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Instruction complete pulse |

## Verification
Each result falls due at a latency that depends on the opcode class, from 1 edge for an unknown opcode to 7 edges for an indirect load. The bench counts rising edges after the accepting edge and samples `done` at each falling edge. A check fails if that count differs from the R8 value.

Strobe counts, the last two read addresses, the write address and the `cc_upd` count are gathered at falling edges over the whole instruction. Register and memory contents are examined only once `done` has been seen. By then the write-back edge and the memory-write edge have both passed.

// File: rtl/ldst_seq_pkg.sv
package ldst_seq_pkg;

  localparam logic [3:0] OPC_LD  = 4'b0010;
  localparam logic [3:0] OPC_ST  = 4'b0011;
  localparam logic [3:0] OPC_LDR = 4'b0110;
  localparam logic [3:0] OPC_STR = 4'b0111;
  localparam logic [3:0] OPC_LDI = 4'b1010;
  localparam logic [3:0] OPC_STI = 4'b1011;
  localparam logic [3:0] OPC_LEA = 4'b1110;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_RD1, S_CAP1, S_INDIR, S_RD2, S_CAP2,
    S_WB, S_SLOAD, S_SWR, S_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    K_NONE, K_LOAD, K_STORE, K_LOADI, K_STOREI, K_EA
  } op_kind_e;

  typedef enum logic {
    A_PCREL, A_BASE
  } addr_src_e;

  typedef struct packed {
    op_kind_e  kind;
    addr_src_e src;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [3:0] opc);
    op_info_t info;
    info.kind = K_NONE;
    info.src  = A_PCREL;
    case (opc)
      OPC_LD:  info.kind = K_LOAD;
      OPC_ST:  info.kind = K_STORE;
      OPC_LDR: begin info.kind = K_LOAD;  info.src = A_BASE; end
      OPC_STR: begin info.kind = K_STORE; info.src = A_BASE; end
      OPC_LDI: info.kind = K_LOADI;
      OPC_STI: info.kind = K_STOREI;
      OPC_LEA: info.kind = K_EA;
      default: info.kind = K_NONE;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/ldst_seq_agen.sv
module ldst_seq_agen
  import ldst_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 16
) (
  input  logic [IW-1:0] ir,
  input  logic [DW-1:0] pc_inc,
  input  logic [DW-1:0] base_val,
  input  addr_src_e     src,
  output logic [DW-1:0] ea
);
  localparam int OFF_PC_W   = 9;
  localparam int OFF_BASE_W = 6;

  logic [DW-1:0] off_pc;
  logic [DW-1:0] off_base;

  assign off_pc   = {{(DW-OFF_PC_W){ir[OFF_PC_W-1]}}, ir[OFF_PC_W-1:0]};
  assign off_base = {{(DW-OFF_BASE_W){ir[OFF_BASE_W-1]}}, ir[OFF_BASE_W-1:0]};

  always_comb begin
    if (src == A_BASE) ea = base_val + off_base;
    else               ea = pc_inc + off_pc;
  end
endmodule

// File: rtl/ldst_seq_fsm.sv
module ldst_seq_fsm
  import ldst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  op_kind_e   kind,
  output seq_state_e state
);
  seq_state_e state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (start) state_nx = S_ADDR;
      S_ADDR: begin
        case (kind)
          K_EA:                      state_nx = S_WB;
          K_LOAD, K_LOADI, K_STOREI: state_nx = S_RD1;
          K_STORE:                   state_nx = S_SLOAD;
          default:                   state_nx = S_DONE;
        endcase
      end
      S_RD1:   state_nx = S_CAP1;
      S_CAP1:  state_nx = (kind == K_LOADI || kind == K_STOREI) ? S_INDIR : S_WB;
      S_INDIR: state_nx = (kind == K_LOADI) ? S_RD2 : S_SLOAD;
      S_RD2:   state_nx = S_CAP2;
      S_CAP2:  state_nx = S_WB;
      S_WB:    state_nx = S_DONE;
      S_SLOAD: state_nx = S_SWR;
      S_SWR:   state_nx = S_DONE;
      S_DONE:  state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/ldst_seq_regs.sv
module ldst_seq_regs
  import ldst_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state,
  input  logic          start,
  input  op_kind_e      kind,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] ea,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] rf_rd_data,
  output logic [IW-1:0] ir,
  output logic [DW-1:0] mar,
  output logic [DW-1:0] mdr
);
  logic          ir_en, mar_en, mdr_en;
  logic [DW-1:0] mar_d, mdr_d;

  assign ir_en = (state == S_IDLE) && start;

  always_comb begin
    mar_en = 1'b0;
    mar_d  = ea;
    case (state)
      S_ADDR:  mar_en = 1'b1;
      S_INDIR: begin mar_en = 1'b1; mar_d = mdr; end
      default: mar_en = 1'b0;
    endcase
  end

  always_comb begin
    mdr_en = 1'b0;
    mdr_d  = mem_rdata;
    case (state)
      S_ADDR:         begin mdr_en = (kind == K_EA); mdr_d = ea; end
      S_CAP1, S_CAP2: mdr_en = 1'b1;
      S_SLOAD:        begin mdr_en = 1'b1; mdr_d = rf_rd_data; end
      default:        mdr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir  <= '0;
      mar <= '0;
      mdr <= '0;
    end else begin
      if (ir_en)  ir  <= instr;
      if (mar_en) mar <= mar_d;
      if (mdr_en) mdr <= mdr_d;
    end
  end
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] pc_inc,
  output logic [RW-1:0] rf_rd_idx,
  input  logic [DW-1:0] rf_rd_data,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [DW-1:0] wb_data,
  output logic          cc_upd,
  output logic          busy,
  output logic          done
);
  localparam int OPC_HI = IW - 1;
  localparam int OPC_LO = IW - 4;
  localparam int DR_LO  = OPC_LO - RW;
  localparam int BR_LO  = DR_LO - RW;

  logic [1:0]    rst_sync;
  logic          rst_q_n;
  seq_state_e    state;
  op_info_t      info;
  logic [IW-1:0] ir;
  logic [DW-1:0] mar, mdr, ea;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign info = decode_op(ir[OPC_HI:OPC_LO]);

  ldst_seq_fsm i_fsm (
    .clk   (clk),
    .rst_n (rst_q_n),
    .start (start),
    .kind  (info.kind),
    .state (state)
  );

  ldst_seq_agen #(.DW(DW), .IW(IW)) i_agen (
    .ir       (ir),
    .pc_inc   (pc_inc),
    .base_val (rf_rd_data),
    .src      (info.src),
    .ea       (ea)
  );

  ldst_seq_regs #(.DW(DW), .IW(IW)) i_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .state      (state),
    .start      (start),
    .kind       (info.kind),
    .instr      (instr),
    .ea         (ea),
    .mem_rdata  (mem_rdata),
    .rf_rd_data (rf_rd_data),
    .ir         (ir),
    .mar        (mar),
    .mdr        (mdr)
  );

  assign rf_rd_idx = (state == S_SLOAD) ? ir[OPC_LO-1:DR_LO] : ir[DR_LO-1:BR_LO];
  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = (state == S_RD1) || (state == S_RD2);
  assign mem_wr    = (state == S_SWR);
  assign wb_en     = (state == S_WB);
  assign cc_upd    = (state == S_WB);
  assign wb_idx    = ir[OPC_LO-1:DR_LO];
  assign wb_data   = mdr;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_addr,
  input logic          wb_en,
  input logic          cc_upd
);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_rd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  p_wr_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> $stable(mem_addr));
  p_cc_with_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> cc_upd);
  p_cc_only_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cc_upd |-> wb_en);
  p_wb_no_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !mem_wr);
  p_wb_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> done);
  p_wr_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr && !wb_en && !done));
endmodule

bind ldst_seq ldst_seq_chk #(.DW(DW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .wb_en    (wb_en),
  .cc_upd   (cc_upd)
);

// File: tb/test_ldst_seq.sv
module test_ldst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] instr = '0, pc_inc = '0;
  logic [2:0]  rf_rd_idx, wb_idx;
  logic [15:0] rf_rd_data, mem_addr, mem_wdata, mem_rdata, wb_data;
  logic mem_rd, mem_wr, wb_en, cc_upd, busy, done;

  logic [15:0] mem [0:(1<<MAW)-1];
  logic [15:0] rf  [0:7];
  logic [15:0] rdq;
  logic        tb_mwe = 1'b0, tb_rwe = 1'b0;
  logic [MAW-1:0] tb_maddr = '0;
  logic [2:0]  tb_raddr = '0;
  logic [15:0] tb_wdata = '0;

  int nchk = 0, nfail = 0;
  int rd_cnt = 0, wr_cnt = 0, wb_cnt = 0, cc_cnt = 0;
  logic [15:0] rd_last = '0, rd_prev = '0, wr_addr_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_seq i_ldst_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_inc(pc_inc),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .cc_upd(cc_upd),
    .busy(busy), .done(done)
  );

  function automatic logic [15:0] mseed(input int i);
    return 16'(i * 40503 + 7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<MAW); i++) mem[i] <= mseed(i);
      for (int i = 0; i < 8; i++) rf[i] <= 16'(i * 16'h1111);
    end else begin
      if (tb_mwe) mem[tb_maddr] <= tb_wdata;
      if (mem_wr) mem[mem_addr[MAW-1:0]] <= mem_wdata;
      if (tb_rwe) rf[tb_raddr] <= tb_wdata;
      if (wb_en)  rf[wb_idx] <= wb_data;
    end
    if (mem_rd) rdq <= mem[mem_addr[MAW-1:0]];
  end
  assign mem_rdata  = rdq;
  assign rf_rd_data = rf[rf_rd_idx];

  always @(negedge clk) begin
    if (mem_rd) begin rd_cnt <= rd_cnt + 1; rd_prev <= rd_last; rd_last <= mem_addr; end
    if (mem_wr) begin wr_cnt <= wr_cnt + 1; wr_addr_last <= mem_addr; end
    if (wb_en)  wb_cnt <= wb_cnt + 1;
    if (cc_upd) cc_cnt <= cc_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke_mem(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); tb_mwe = 1'b1; tb_maddr = a[MAW-1:0]; tb_wdata = d;
    @(negedge clk); tb_mwe = 1'b0;
  endtask

  task automatic poke_rf(input logic [2:0] r, input logic [15:0] d);
    @(negedge clk); tb_rwe = 1'b1; tb_raddr = r; tb_wdata = d;
    @(negedge clk); tb_rwe = 1'b0;
  endtask

  function automatic logic [15:0] sx9(input logic [15:0] v);
    return {{7{v[8]}}, v[8:0]};
  endfunction
  function automatic logic [15:0] sx6(input logic [15:0] v);
    return {{10{v[5]}}, v[5:0]};
  endfunction
  function automatic logic [15:0] mv(input logic [15:0] a);
    return mem[a[MAW-1:0]];
  endfunction

  task automatic run(input logic [15:0] ins, input logic [15:0] pc, input bit disturb);
    logic [3:0]  opc = ins[15:12];
    logic [2:0]  dr  = ins[11:9];
    logic [15:0] pcrel = pc + sx9(ins);
    logic [15:0] based = rf[ins[8:6]] + sx6(ins);
    logic [15:0] ea = pcrel, target = '0, val = '0;
    int lat_e = 1, rds = 0, wrs = 0, wbs = 0;
    string tg = "R9";
    int r0, w0, b0, c0, lat;
    bit seen;
    case (opc)
      4'b0010: begin tg = "R2"; lat_e = 4; rds = 1; wbs = 1; val = mv(ea); end
      4'b0110: begin tg = "R3"; ea = based; lat_e = 4; rds = 1; wbs = 1; val = mv(ea); end
      4'b1010: begin tg = "R4"; lat_e = 7; rds = 2; wbs = 1; target = mv(ea); val = mv(target); end
      4'b0011: begin tg = "R2"; lat_e = 3; wrs = 1; target = ea; val = rf[dr]; end
      4'b0111: begin tg = "R3"; ea = based; lat_e = 3; wrs = 1; target = ea; val = rf[dr]; end
      4'b1011: begin tg = "R4"; lat_e = 6; rds = 1; wrs = 1; target = mv(ea); val = rf[dr]; end
      4'b1110: begin tg = "R5"; lat_e = 2; wbs = 1; val = pcrel; end
      default: begin tg = "R9"; lat_e = 1; end
    endcase
    r0 = rd_cnt; w0 = wr_cnt; b0 = wb_cnt; c0 = cc_cnt;
    @(negedge clk); instr = ins; pc_inc = pc; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = disturb;
    if (disturb) instr = ~ins;
    lat = 0; seen = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(posedge clk); lat++;
      @(negedge clk);
      start = 1'b0; instr = ins;
      if (done) seen = 1'b1;
    end
    check(seen && lat == lat_e, disturb ? "R8/R10 latency" : "R8 latency", 32'(lat), 32'(lat_e));
    check(rd_cnt - r0 == rds, {tg, " read count R11"}, 32'(rd_cnt - r0), 32'(rds));
    check(wr_cnt - w0 == wrs, {tg, " write count R6"}, 32'(wr_cnt - w0), 32'(wrs));
    check(wb_cnt - b0 == wbs, {tg, " writeback count R6"}, 32'(wb_cnt - b0), 32'(wbs));
    check(cc_cnt - c0 == wbs, {tg, " cc update R7"}, 32'(cc_cnt - c0), 32'(wbs));
    if (rds == 1 && wrs == 0) check(rd_last == ea, {tg, " read address"}, 32'(rd_last), 32'(ea));
    if (rds == 2) begin
      check(rd_prev == ea, "R4 first read address", 32'(rd_prev), 32'(ea));
      check(rd_last == target, "R4 second read address", 32'(rd_last), 32'(target));
    end
    if (rds == 1 && wrs == 1) check(rd_last == ea, "R4 pointer read address", 32'(rd_last), 32'(ea));
    if (wbs == 1) check(rf[dr] == val, {tg, " loaded value R6"}, 32'(rf[dr]), 32'(val));
    if (wrs == 1) begin
      check(wr_addr_last == target, {tg, " store address"}, 32'(wr_addr_last), 32'(target));
      check(mv(target) == val, {tg, " stored value R6"}, 32'(mv(target)), 32'(val));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [3:0] codes [0:7];
    logic [15:0] ri;
    codes[0] = 4'b0010; codes[1] = 4'b0011; codes[2] = 4'b0110; codes[3] = 4'b0111;
    codes[4] = 4'b1010; codes[5] = 4'b1011; codes[6] = 4'b1110; codes[7] = 4'b0001;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!done && !busy && !mem_rd && !mem_wr && !wb_en && !cc_upd, "R1 in reset",
          {26'd0, done, busy, mem_rd, mem_wr, wb_en, cc_upd}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && !busy && !mem_rd && !mem_wr && !wb_en && !cc_upd, "R1 after release",
          {26'd0, done, busy, mem_rd, mem_wr, wb_en, cc_upd}, 32'd0);

    // R4: pointer load, pc x4A1C, pointer cell holds x2110
    poke_mem(16'h49E8, 16'h2110);
    poke_mem(16'h2110, 16'hBEEF);
    run(16'hA7CC, 16'h4A1C, 1'b0);
    check(rf[3] == 16'hBEEF, "R4 directed value", 32'(rf[3]), 32'hBEEF);
    // R3: base x2345 + x1D
    poke_rf(3'd2, 16'h2345);
    poke_mem(16'h2362, 16'h0F0F);
    run(16'h629D, 16'h0000, 1'b0);
    check(rf[1] == 16'h0F0F, "R3 directed value", 32'(rf[1]), 32'h0F0F);
    // R5: address-only, pc x4019, offset -3
    run(16'hEBFD, 16'h4019, 1'b0);
    check(rf[5] == 16'h4016, "R5 directed value", 32'(rf[5]), 32'h4016);
    // R2 reach extremes
    run(16'h20FF, 16'h1000, 1'b0);
    run(16'h2100, 16'h1000, 1'b0);
    run(16'h3500, 16'h0200, 1'b0);
    // R3 offset extremes
    run(16'h6620, 16'h0000, 1'b0);
    run(16'h761F, 16'h0000, 1'b0);
    // R4 pointer store
    run(16'hB9F0, 16'h0800, 1'b0);
    // R9 unknown opcodes
    run(16'h1234, 16'h0000, 1'b0);
    run(16'hF0F0, 16'h0000, 1'b0);
    // R10 start and instr changes while busy
    run(16'hA401, 16'h0300, 1'b1);
    run(16'h3A10, 16'h0400, 1'b1);

    for (int n = 0; n < 120; n++) begin
      ri = 16'($urandom);
      ri[15:12] = codes[$urandom_range(0, 7)];
      if ($urandom_range(0, 3) == 0) poke_rf(3'($urandom_range(0, 7)), 16'($urandom));
      run(ri, 16'($urandom), 1'($urandom_range(0, 4) == 0));
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule